// File: doc/BRIEF.md
# Reloading compare time base timer

This block is a free-running up-counter that gives a bank of compare registers a shared time base for fast output edges or pulse-width modulation. Its step rate comes from a power-of-two prescaler chosen in an 8-bit control register. When the count passes all ones it does not wrap to zero. It restarts from a programmable reload value, which sets the period of the time base.

At that restart the block raises an overflow flag, which can drive an interrupt request. The flag drops by itself on the tick that moves the count off the reload value. The block also watches two thresholds, a "set" threshold and a "clear" threshold. When the count meets either one, it gives a one-cycle pulse and sets a sticky flag. That flag stays up until the interrupt controller acknowledges it.

Software reaches the block through a byte-wide write bus. Address 0 is the control register, address 1 is the low reload byte and address 2 is the high reload byte. The control register can be read back at all times on a separate port.

Top module: `cmp_timebase`

## Requirements
- R1: After reset, `count` is 0, `ctrl_rd` is 8'h40, the reload value is 0, and all flags, pulses and `ovf_irq` are 0.
- R2: With prescale code k in control bits 2:0, `count` advances by one exactly once every 2^k clock cycles, so any 128 consecutive cycles give 128 >> k steps.
- R3: On the step from all ones, `count` takes the reload value instead of zero.
- R4: A write to address 1 sets reload bits 7:0 and a write to address 2 sets bits 15:8. A reload write never alters `count`. The new value is first used at the next rollover.
- R5: The overflow flag, read in control bit 3, is set on the rollover step. It stays set while the count equals the reload value and clears on the step that moves the count on.
- R6: `ovf_irq` is high exactly while the overflow flag is set and `ovf_irq_en` is high.
- R7: On a counting step whose old count equals `set_thr` (or `clr_thr`), `set_pulse` (or `clr_pulse`) is high for the next cycle, and `set_flag` (or `clr_flag`) is set. These flags also read back in control bits 4 and 5.
- R8: `set_ack` (or `clr_ack`) held for one cycle clears its flag. If an acknowledge and a new match for the same flag come in the same cycle, the flag stays set.
- R9: A control write stores bits 2:0, 6 and 7 and ignores bits 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 reload low, 2 reload high |
| bus_wdata | input | 8 | Write data |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| set_thr | input | 16 | Set-compare threshold |
| clr_thr | input | 16 | Clear-compare threshold |
| set_ack | input | 1 | Acknowledge of the set-compare interrupt |
| clr_ack | input | 1 | Acknowledge of the clear-compare interrupt |
| count | output | 16 | Current time base value |
| ctrl_rd | output | 8 | Control register readback |
| ovf_irq | output | 1 | Overflow interrupt request |
| set_pulse | output | 1 | One-cycle set-compare match pulse |
| clr_pulse | output | 1 | One-cycle clear-compare match pulse |
| set_flag | output | 1 | Sticky set-compare flag |
| clr_flag | output | 1 | Sticky clear-compare flag |

## Verification
The bench builds the block with its default 16-bit count and 3-bit prescale select. Every code from 0 to 7 therefore maps to a real divide ratio, from 1 to 128, and each one can be measured over a 128-cycle window. With a 16-bit count, the first pass from reset up to all ones is short enough to run to the end. After that, a reload near the top of the range shortens the period to a few cycles. This makes repeated rollovers, a reload change between rollovers, and compare matches that coincide with acknowledges all cheap to reach.

// File: rtl/cmp_timebase.sv
module cmp_timebase #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             ovf_irq_en,
  input  logic [CNT_W-1:0] set_thr,
  input  logic [CNT_W-1:0] clr_thr,
  input  logic             set_ack,
  input  logic             clr_ack,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       ctrl_rd,
  output logic             ovf_irq,
  output logic             set_pulse,
  output logic             clr_pulse,
  output logic             set_flag,
  output logic             clr_flag
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel;
  logic [1:0]       spare;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;
  logic [CNT_W-1:0] reload;
  logic             ovf;
  logic             tick, at_top, set_hit, clr_hit;

  assign mask    = ~({PRE_W{1'b1}} << sel);
  assign tick    = (pre & mask) == mask;
  assign at_top  = &count;
  assign set_hit = tick && (count == set_thr);
  assign clr_hit = tick && (count == clr_thr);
  assign ovf_irq = ovf && ovf_irq_en;
  assign ctrl_rd = {spare, clr_flag, set_flag, ovf, sel};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel    <= '0;
      spare  <= 2'b01;
      reload <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        2'd0: begin
          sel   <= bus_wdata[SEL_W-1:0];
          spare <= bus_wdata[7:6];
        end
        2'd1: reload[7:0] <= bus_wdata;
        2'd2: reload[CNT_W-1:8] <= bus_wdata[CNT_W-9:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (tick) begin
      count <= at_top ? reload : count + 1'b1;
      ovf   <= at_top;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_pulse <= 1'b0;
      clr_pulse <= 1'b0;
      set_flag  <= 1'b0;
      clr_flag  <= 1'b0;
    end else begin
      set_pulse <= set_hit;
      clr_pulse <= clr_hit;
      set_flag  <= set_hit || (set_flag && !set_ack);
      clr_flag  <= clr_hit || (clr_flag && !clr_ack);
    end
  end
endmodule

// File: rtl/cmp_timebase_chk.sv
module cmp_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] set_thr,
  input logic [7:0]       ctrl_rd,
  input logic             ovf_irq,
  input logic             ovf_irq_en,
  input logic             set_pulse,
  input logic             set_flag,
  input logic             set_ack,
  input logic             clr_flag,
  input logic             clr_ack
);
  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(&count) |=> (count == $past(count) || count == $past(count) + 1'b1));

  assert_ovf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rd[3]) |-> &$past(count));

  assert_ovf_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rd[3]) |-> count != $past(count));

  assert_irq_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> (ovf_irq_en && ctrl_rd[3]));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |-> (set_flag && $past(count) == $past(set_thr)));

  assert_set_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(set_flag) |-> $past(set_ack));

  assert_clr_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr_flag) |-> $past(clr_ack));
endmodule

bind cmp_timebase cmp_timebase_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .set_thr(set_thr),
  .ctrl_rd(ctrl_rd), .ovf_irq(ovf_irq), .ovf_irq_en(ovf_irq_en),
  .set_pulse(set_pulse), .set_flag(set_flag), .set_ack(set_ack),
  .clr_flag(clr_flag), .clr_ack(clr_ack)
);

// File: tb/test_cmp_timebase.sv
`timescale 1ns/1ps
module test_cmp_timebase;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic        ovf_irq_en;
  logic [15:0] set_thr, clr_thr;
  logic        set_ack, clr_ack;
  logic [15:0] count;
  logic [7:0]  ctrl_rd;
  logic        ovf_irq, set_pulse, clr_pulse, set_flag, clr_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] c0;

  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {3'd0, 8'd128}, {3'd3, 8'd16}, {3'd1, 8'd64}, {3'd7, 8'd1},
    {3'd2, 8'd32},  {3'd5, 8'd4},  {3'd4, 8'd8},  {3'd6, 8'd2}
  };

  always #2.5 clk = ~clk;

  cmp_timebase i_cmp_timebase (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ovf_irq_en(ovf_irq_en), .set_thr(set_thr),
    .clr_thr(clr_thr), .set_ack(set_ack), .clr_ack(clr_ack),
    .count(count), .ctrl_rd(ctrl_rd), .ovf_irq(ovf_irq),
    .set_pulse(set_pulse), .clr_pulse(clr_pulse),
    .set_flag(set_flag), .clr_flag(clr_flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_count(input logic [15:0] v);
    while (count !== v) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual expired expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    ovf_irq_en = 1'b1; set_thr = 16'hFFF4; clr_thr = 16'hFFF8;
    set_ack = 1'b0; clr_ack = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 count", count, 0);
    check("R1 ctrl", ctrl_rd, 8'h40);
    check("R1 flags", {ovf_irq, set_pulse, clr_pulse, set_flag, clr_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(2'd0, {5'b01000, VEC[i][10:8]});
      c0 = count;
      repeat (128) @(negedge clk);
      check($sformatf("R2 sel %0d", VEC[i][10:8]), 32'(count - c0), 32'(VEC[i][7:0]));
    end

    wr(2'd0, 8'hFF);
    check("R9 ignore bits 5:3", ctrl_rd, 8'hC7);
    wr(2'd0, 8'h00);
    check("R9 clear stored", ctrl_rd, 8'h00);

    wr(2'd1, 8'hF0);
    c0 = count;
    wr(2'd2, 8'hFF);
    check("R4 no count disturb", count, 32'(c0 + 16'd1));

    wait_count(16'hFFFF);
    @(negedge clk);
    check("R3 rollover to reload", count, 16'hFFF0);
    check("R5 flag set", ctrl_rd[3], 1);
    check("R6 irq enabled", ovf_irq, 1);
    @(negedge clk);
    check("R5 flag cleared", ctrl_rd[3], 0);
    check("R6 irq drops", ovf_irq, 0);

    ovf_irq_en = 1'b0;
    wait_count(16'hFFFF);
    @(negedge clk);
    check("R5 flag second roll", ctrl_rd[3], 1);
    check("R6 irq masked", ovf_irq, 0);

    wr(2'd1, 8'hFA);
    check("R4 count kept", count, 16'hFFF1);
    wait_count(16'hFFFF);
    @(negedge clk);
    check("R4 new reload used", count, 16'hFFFA);

    set_thr = 16'hFFFC; clr_thr = 16'hFFFD;
    wait_count(16'hFFFB);
    set_ack = 1'b1; clr_ack = 1'b1;
    @(negedge clk);
    set_ack = 1'b0; clr_ack = 1'b0;
    check("R8 ack clears", {set_flag, clr_flag}, 0);
    @(negedge clk);
    check("R7 set pulse", {set_pulse, set_flag, clr_pulse}, 3'b110);
    @(negedge clk);
    check("R7 set pulse one cycle", {set_pulse, set_flag}, 2'b01);
    check("R7 clr pulse", {clr_pulse, clr_flag}, 2'b11);
    check("R7 readback bits 5:4", ctrl_rd[5:4], 2'b11);

    wait_count(16'hFFFD);
    set_ack = 1'b1; clr_ack = 1'b1;
    @(negedge clk);
    set_ack = 1'b0; clr_ack = 1'b0;
    check("R8 match beats ack", clr_flag, 1);
    check("R8 ack without match", set_flag, 0);

    done = 1'b1;
    finish_run();
  end
endmodule